// File: doc/BRIEF.md
# Receive Queue with Error-Tagged Entries and Status Interrupts

This block sits between a serial deserializer and a register bus in an asynchronous receiver. Every received byte is queued together with two tag bits, one for a missing stop bit (framing) and one for a line break. The tags travel with the byte, so an error becomes visible to software only when the offending byte is the next one to be read. Errors do not show up at the moment the byte arrives. A separate summary flag stays high for as long as any tagged byte is still anywhere in the queue.

A byte that arrives while the queue is full is dropped, and a sticky overrun flag is raised at once. Reading the line-status image acknowledges the pending line interrupt. A later pop that brings a different tagged byte to the head raises the interrupt again. Four modem-status inputs are synchronised, and each edge sets a change bit. The change bits drive a second interrupt, which is cleared by reading the modem-status image. The queue depth is a parameter. A depth of one turns the queue into a single holding register.

Top module: `uart_rx_errfifo`

## Requirements
- R1: After a synchronous reset the queue is empty, `lsr` and `msr` read 0, and both interrupt outputs are low.
- R2: Bytes are read in arrival order. `rd_data` shows the head byte, or 0 when the queue is empty. `lsr[0]` is 1 exactly when the queue holds a byte, and `rd_en` pops one byte.
- R3: A tagged byte written behind an untagged head does not raise `irq_line`.
- R4: `irq_line` is high while the head byte is tagged and has not been acknowledged, or while the overrun flag is set, and only when `ie_line` is 1.
- R5: A cycle with `lsr_rd` high acknowledges the head error, and `irq_line` is low in the next cycle. The interrupt rises again only after a pop brings a tagged byte to the head.
- R6: `lsr[4]` is 1 while at least one tagged byte remains anywhere in the queue.
- R7: `lsr[2]` is the framing tag of the head byte and `lsr[3]` is its break tag. Both bits are 0 when the queue is empty.
- R8: A write to a full queue drops the byte and sets `lsr[1]` in the next cycle, which raises `irq_line` when enabled. `lsr[1]` clears after an `lsr_rd` cycle. An overrun in the same cycle as `lsr_rd` wins.
- R9: Each modem input passes through two flops. `msr[7:4]` shows the synchronised levels. Each edge sets the matching bit of `msr[3:0]` one cycle after the level shows. `irq_modem` is the OR of `msr[3:0]` gated by `ie_modem`. An `msr_rd` cycle clears the bits that saw no new edge.
- R10: With depth 1, a second byte written before the first is read causes an overrun, and the first byte is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Received-byte strobe from the deserializer |
| wr_data | input | 8 | Received byte |
| wr_frame_err | input | 1 | Byte lacked a valid stop bit |
| wr_break | input | 1 | Byte was a line break |
| rd_en | input | 1 | Data read: pop the head byte |
| lsr_rd | input | 1 | Line-status image read |
| msr_rd | input | 1 | Modem-status image read |
| modem_in | input | 4 | Asynchronous modem-status inputs |
| ie_line | input | 1 | Line-status interrupt enable |
| ie_modem | input | 1 | Modem-status interrupt enable |
| rd_data | output | 8 | Head byte |
| lsr | output | 8 | Line-status image |
| msr | output | 8 | Modem-status image: levels [7:4], change bits [3:0] |
| irq_line | output | 1 | Line-status interrupt request |
| irq_modem | output | 1 | Modem-status interrupt request |

## Verification
The bench places a tagged byte behind a clean one. A design that signals errors on arrival would raise the interrupt too early. The bench acknowledges a tagged head and then pops onto a second tagged byte, which catches both an acknowledge that never re-arms and one that re-arms without a pop. It fills the queue and writes one byte more, to catch a dropped byte that still gets stored or an overrun flag that never clears. It also runs the depth-one variant and checks the exact cycle in which a modem edge first appears, to catch a missing synchroniser stage.

// File: rtl/uart_rxf_pkg.sv
package uart_rxf_pkg;

    localparam int BYTE_W = 8;

    typedef struct packed {
        logic              brk;
        logic              fe;
        logic [BYTE_W-1:0] data;
    } rx_entry_t;

    typedef struct packed {
        logic [2:0] rsvd;
        logic       err_any;
        logic       head_brk;
        logic       head_fe;
        logic       ovr;
        logic       ready;
    } lsr_t;

    function automatic logic entry_bad(rx_entry_t e);
        return e.brk | e.fe;
    endfunction

endpackage

// File: rtl/uart_rxf_store.sv
module uart_rxf_store
    import uart_rxf_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      push,
    input  logic      pop,
    input  rx_entry_t push_entry,
    output rx_entry_t head,
    output logic      empty,
    output logic      full
);
    generate
        if (DEPTH == 1) begin : g_hold
            rx_entry_t hold_q;
            logic      valid_q;

            always_ff @(posedge clk) begin
                if (rst) begin
                    valid_q <= 1'b0;
                    hold_q  <= '0;
                end else if (push) begin
                    valid_q <= 1'b1;
                    hold_q  <= push_entry;
                end else if (pop) begin
                    valid_q <= 1'b0;
                end
            end

            assign head  = hold_q;
            assign empty = ~valid_q;
            assign full  = valid_q;
        end else begin : g_ring
            localparam int PW = $clog2(DEPTH);
            localparam int CW = $clog2(DEPTH + 1);

            rx_entry_t       mem [DEPTH];
            logic [PW-1:0]   wptr_q, rptr_q;
            logic [CW-1:0]   cnt_q;

            function automatic logic [PW-1:0] adv(logic [PW-1:0] p);
                return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
            endfunction

            always_ff @(posedge clk) begin
                if (rst) begin
                    wptr_q <= '0;
                    rptr_q <= '0;
                    cnt_q  <= '0;
                end else begin
                    if (push) begin
                        mem[wptr_q] <= push_entry;
                        wptr_q      <= adv(wptr_q);
                    end
                    if (pop) begin
                        rptr_q <= adv(rptr_q);
                    end
                    cnt_q <= cnt_q + CW'(push) - CW'(pop);
                end
            end

            assign head  = mem[rptr_q];
            assign empty = (cnt_q == '0);
            assign full  = (cnt_q == CW'(DEPTH));
        end
    endgenerate
endmodule

// File: rtl/uart_rxf_linestat.sv
module uart_rxf_linestat #(
    parameter int DEPTH = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic push,
    input  logic push_bad,
    input  logic pop,
    input  logic head_bad,
    input  logic overrun,
    input  logic lsr_rd,
    output logic err_any,
    output logic ovr_flag,
    output logic line_src
);
    localparam int CW = $clog2(DEPTH + 1);

    logic [CW-1:0] bad_cnt_q;
    logic          head_ack_q;
    logic          ovr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            bad_cnt_q  <= '0;
            head_ack_q <= 1'b0;
            ovr_q      <= 1'b0;
        end else begin
            bad_cnt_q <= bad_cnt_q + CW'(push & push_bad) - CW'(pop & head_bad);

            if (pop) begin
                head_ack_q <= 1'b0;
            end else if (lsr_rd && head_bad) begin
                head_ack_q <= 1'b1;
            end

            if (overrun) begin
                ovr_q <= 1'b1;
            end else if (lsr_rd) begin
                ovr_q <= 1'b0;
            end
        end
    end

    assign err_any  = (bad_cnt_q != '0);
    assign ovr_flag = ovr_q;
    assign line_src = ovr_q | (head_bad & ~head_ack_q);
endmodule

// File: rtl/uart_rxf_modem.sv
module uart_rxf_modem #(
    parameter int MW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [MW-1:0] pins,
    input  logic          msr_rd,
    output logic [MW-1:0] level,
    output logic [MW-1:0] delta
);
    logic [MW-1:0] s1_q, s2_q, s3_q, delta_q;
    logic [MW-1:0] edge_w;

    assign edge_w = s2_q ^ s3_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_q    <= '0;
            s2_q    <= '0;
            s3_q    <= '0;
            delta_q <= '0;
        end else begin
            s1_q    <= pins;
            s2_q    <= s1_q;
            s3_q    <= s2_q;
            delta_q <= msr_rd ? edge_w : (delta_q | edge_w);
        end
    end

    assign level = s2_q;
    assign delta = delta_q;
endmodule

// File: rtl/uart_rx_errfifo.sv
module uart_rx_errfifo
    import uart_rxf_pkg::*;
#(
    parameter int DEPTH   = 16,
    parameter int MODEM_W = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [BYTE_W-1:0]    wr_data,
    input  logic                 wr_frame_err,
    input  logic                 wr_break,
    input  logic                 rd_en,
    input  logic                 lsr_rd,
    input  logic                 msr_rd,
    input  logic [MODEM_W-1:0]   modem_in,
    input  logic                 ie_line,
    input  logic                 ie_modem,
    output logic [BYTE_W-1:0]    rd_data,
    output logic [7:0]           lsr,
    output logic [2*MODEM_W-1:0] msr,
    output logic                 irq_line,
    output logic                 irq_modem
);
    rx_entry_t     in_entry, head;
    logic          empty, full, push, pop, overrun, head_bad;
    logic          err_any, ovr_flag, line_src;
    logic [MODEM_W-1:0] m_level, m_delta;
    lsr_t          lsr_img;

    assign in_entry = '{brk: wr_break, fe: wr_frame_err, data: wr_data};
    assign push     = wr_en & ~full;
    assign overrun  = wr_en & full;
    assign pop      = rd_en & ~empty;
    assign head_bad = ~empty & entry_bad(head);

    uart_rxf_store #(.DEPTH(DEPTH)) u_store (
        .clk(clk), .rst(rst), .push(push), .pop(pop),
        .push_entry(in_entry), .head(head), .empty(empty), .full(full)
    );

    uart_rxf_linestat #(.DEPTH(DEPTH)) u_line (
        .clk(clk), .rst(rst), .push(push), .push_bad(entry_bad(in_entry)),
        .pop(pop), .head_bad(head_bad), .overrun(overrun), .lsr_rd(lsr_rd),
        .err_any(err_any), .ovr_flag(ovr_flag), .line_src(line_src)
    );

    uart_rxf_modem #(.MW(MODEM_W)) u_modem (
        .clk(clk), .rst(rst), .pins(modem_in), .msr_rd(msr_rd),
        .level(m_level), .delta(m_delta)
    );

    always_comb begin
        lsr_img          = '0;
        lsr_img.ready    = ~empty;
        lsr_img.ovr      = ovr_flag;
        lsr_img.head_fe  = ~empty & head.fe;
        lsr_img.head_brk = ~empty & head.brk;
        lsr_img.err_any  = err_any;
    end

    assign lsr       = lsr_img;
    assign rd_data   = empty ? '0 : head.data;
    assign msr       = {m_level, m_delta};
    assign irq_line  = ie_line & line_src;
    assign irq_modem = ie_modem & (|m_delta);
endmodule

// File: rtl/uart_rx_errfifo_chk.sv
module uart_rx_errfifo_chk (
    input logic       clk,
    input logic       rst,
    input logic       wr_en,
    input logic       rd_en,
    input logic       lsr_rd,
    input logic       ie_line,
    input logic       ie_modem,
    input logic [7:0] rd_data,
    input logic [7:0] lsr,
    input logic       irq_line,
    input logic       irq_modem
);
    assert_empty_no_err_R6: assert property (@(posedge clk) disable iff (rst)
        !lsr[0] |-> (!lsr[4] && lsr[3:2] == 2'b00));

    assert_empty_data_zero_R2: assert property (@(posedge clk) disable iff (rst)
        !lsr[0] |-> rd_data == 8'h00);

    assert_irq_has_source_R4: assert property (@(posedge clk) disable iff (rst)
        irq_line |-> (ie_line && (lsr[1] || lsr[2] || lsr[3])));

    assert_ack_clears_R5: assert property (@(posedge clk) disable iff (rst)
        (lsr_rd && !wr_en && !rd_en) |=> !irq_line);

    assert_ovr_needs_write_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(lsr[1]) |-> $past(wr_en));

    assert_modem_gated_R9: assert property (@(posedge clk) disable iff (rst)
        irq_modem |-> ie_modem);
endmodule

bind uart_rx_errfifo uart_rx_errfifo_chk i_chk (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .lsr_rd(lsr_rd),
    .ie_line(ie_line), .ie_modem(ie_modem), .rd_data(rd_data), .lsr(lsr),
    .irq_line(irq_line), .irq_modem(irq_modem)
);

// File: tb/uart_rx_errfifo_model.sv
module uart_rx_errfifo_model #(
    parameter int DEPTH = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    input  logic       wr_frame_err,
    input  logic       wr_break,
    input  logic       rd_en,
    input  logic       lsr_rd,
    input  logic       msr_rd,
    input  logic [3:0] modem_in,
    output logic       m_empty,
    output logic [9:0] m_head,
    output logic       m_bad,
    output logic       m_ovr,
    output logic       m_ack,
    output logic [3:0] m_lvl,
    output logic [3:0] m_delta
);
    logic [9:0] q[$];
    logic [3:0] p1, p2, p3;

    initial begin
        m_empty = 1'b1; m_head = '0; m_bad = 1'b0; m_ovr = 1'b0; m_ack = 1'b0;
        m_lvl = '0; m_delta = '0; p1 = '0; p2 = '0; p3 = '0;
    end

    always @(posedge clk) begin
        if (rst) begin
            q.delete();
            m_ovr = 1'b0; m_ack = 1'b0; m_delta = '0;
            p1 = '0; p2 = '0; p3 = '0;
        end else begin
            int sz;
            logic head_bad, do_pop, ovr_ev;
            sz       = q.size();
            head_bad = (sz != 0) && (q[0][9] || q[0][8]);
            do_pop   = rd_en && (sz != 0);
            ovr_ev   = wr_en && (sz == DEPTH);
            if (do_pop) m_ack = 1'b0;
            else if (lsr_rd && head_bad) m_ack = 1'b1;
            if (ovr_ev) m_ovr = 1'b1;
            else if (lsr_rd) m_ovr = 1'b0;
            if (do_pop) void'(q.pop_front());
            if (wr_en && sz < DEPTH) q.push_back({wr_break, wr_frame_err, wr_data});
            m_delta = msr_rd ? (p2 ^ p3) : (m_delta | (p2 ^ p3));
            p3 = p2; p2 = p1; p1 = modem_in;
        end
        m_empty = (q.size() == 0);
        m_head  = m_empty ? 10'h0 : q[0];
        m_bad   = 1'b0;
        foreach (q[i]) if (q[i][9] || q[i][8]) m_bad = 1'b1;
        m_lvl   = p2;
    end
endmodule

// File: tb/test_uart_rx_errfifo.sv
module test_uart_rx_errfifo;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic wr_en = 0, wr_fe = 0, wr_brk = 0, rd_en = 0, lsr_rd = 0, msr_rd = 0;
    logic ie_line = 0, ie_modem = 0;
    logic [7:0] wr_data = '0;
    logic [3:0] modem_in = '0;

    logic [7:0] rd0, lsr0, msr0, rd1, lsr1, msr1;
    logic       irql0, irqm0, irql1, irqm1;

    logic       e0, e1, b0, b1, o0, o1, a0, a1;
    logic [9:0] h0, h1;
    logic [3:0] l0, l1, d0, d1;

    int n_chk = 0, n_bad = 0, cycles = 0;
    logic chk_on = 1'b0, done = 1'b0;

    always #5 clk = ~clk;

    uart_rx_errfifo #(.DEPTH(16)) i_uart_rx_errfifo (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .wr_frame_err(wr_fe),
        .wr_break(wr_brk), .rd_en(rd_en), .lsr_rd(lsr_rd), .msr_rd(msr_rd),
        .modem_in(modem_in), .ie_line(ie_line), .ie_modem(ie_modem),
        .rd_data(rd0), .lsr(lsr0), .msr(msr0), .irq_line(irql0), .irq_modem(irqm0));

    uart_rx_errfifo #(.DEPTH(1)) i_uart_rx_errfifo_d1 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .wr_frame_err(wr_fe),
        .wr_break(wr_brk), .rd_en(rd_en), .lsr_rd(lsr_rd), .msr_rd(msr_rd),
        .modem_in(modem_in), .ie_line(ie_line), .ie_modem(ie_modem),
        .rd_data(rd1), .lsr(lsr1), .msr(msr1), .irq_line(irql1), .irq_modem(irqm1));

    uart_rx_errfifo_model #(.DEPTH(16)) u_ref0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .wr_frame_err(wr_fe),
        .wr_break(wr_brk), .rd_en(rd_en), .lsr_rd(lsr_rd), .msr_rd(msr_rd),
        .modem_in(modem_in), .m_empty(e0), .m_head(h0), .m_bad(b0), .m_ovr(o0),
        .m_ack(a0), .m_lvl(l0), .m_delta(d0));

    uart_rx_errfifo_model #(.DEPTH(1)) u_ref1 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .wr_frame_err(wr_fe),
        .wr_break(wr_brk), .rd_en(rd_en), .lsr_rd(lsr_rd), .msr_rd(msr_rd),
        .modem_in(modem_in), .m_empty(e1), .m_head(h1), .m_bad(b1), .m_ovr(o1),
        .m_ack(a1), .m_lvl(l1), .m_delta(d1));

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h t=%0t", req, what, act, exp, $time);
        end
    endtask

    task automatic cmp(string sfx, logic [7:0] rd, logic [7:0] ls, logic [7:0] ms,
                       logic il, logic im, logic e, logic [9:0] h, logic b,
                       logic o, logic a, logic [3:0] l, logic [3:0] d);
        logic hb;
        hb = !e && (h[9] || h[8]);
        check({"R2", sfx}, "rd_data", rd, e ? 8'h00 : h[7:0]);
        check({"R2", sfx}, "lsr.ready", ls[0], !e);
        check({"R8", sfx}, "lsr.ovr", ls[1], o);
        check({"R7", sfx}, "lsr.tags", ls[3:2], e ? 2'b00 : {h[9], h[8]});
        check({"R6", sfx}, "lsr.err", ls[4], b);
        check({"R4", sfx}, "lsr.rsvd", ls[7:5], 3'b000);
        check({"R4", sfx}, "irq_line", il, ie_line && (o || (hb && !a)));
        check({"R9", sfx}, "msr", ms, {l, d});
        check({"R9", sfx}, "irq_modem", im, ie_modem && (|d));
    endtask

    always @(negedge clk) begin
        if (chk_on && !done) begin
            cmp("", rd0, lsr0, msr0, irql0, irqm0, e0, h0, b0, o0, a0, l0, d0);
            cmp(" R10", rd1, lsr1, msr1, irql1, irqm1, e1, h1, b1, o1, a1, l1, d1);
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            done = 1'b1;
            n_chk++; n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    task automatic tick();
        @(posedge clk); #1;
        wr_en = 0; wr_fe = 0; wr_brk = 0; rd_en = 0; lsr_rd = 0; msr_rd = 0;
    endtask

    task automatic put(logic [7:0] d, logic fe, logic brk);
        wr_en = 1; wr_data = d; wr_fe = fe; wr_brk = brk;
        tick();
    endtask

    task automatic pop1();
        rd_en = 1;
        tick();
    endtask

    initial begin
        rst = 1;
        repeat (3) tick();
        rst = 0;
        tick();
        chk_on = 1'b1;
        #1;
        check("R1", "lsr after reset", lsr0, 8'h00);
        check("R1", "msr after reset", msr0, 8'h00);
        check("R1", "irq_line after reset", irql0, 1'b0);
        check("R1", "irq_modem after reset", irqm0, 1'b0);

        ie_line = 1; ie_modem = 1;
        put(8'h11, 0, 0);
        put(8'h22, 1, 0);
        #1;
        check("R3", "irq with tagged byte behind head", irql0, 1'b0);
        check("R6", "err with tagged byte queued", lsr0[4], 1'b1);
        check("R10", "depth1 overrun flag", lsr1[1], 1'b1);
        check("R10", "depth1 keeps first byte", rd1, 8'h11);

        pop1(); #1;
        check("R2", "second byte at head", rd0, 8'h22);
        check("R4", "irq when tagged head", irql0, 1'b1);
        check("R7", "framing tag of head", lsr0[3:2], 2'b01);
        ie_line = 0; #1;
        check("R4", "irq gated off", irql0, 1'b0);
        ie_line = 1;

        lsr_rd = 1; tick(); #1;
        check("R5", "irq cleared by status read", irql0, 1'b0);
        put(8'h33, 0, 1); #1;
        check("R5", "no retrigger on same head", irql0, 1'b0);
        pop1(); #1;
        check("R5", "rearmed on new tagged head", irql0, 1'b1);
        check("R7", "break tag of head", lsr0[3:2], 2'b10);
        pop1(); #1;
        check("R6", "lsr clear after draining", lsr0, 8'h00);

        for (int i = 0; i < 17; i++) put(8'h40 + 8'(i), 0, 0);
        #1;
        check("R8", "overrun flag", lsr0[1], 1'b1);
        check("R8", "overrun irq", irql0, 1'b1);
        check("R8", "head kept on overrun", rd0, 8'h40);
        lsr_rd = 1; tick(); #1;
        check("R8", "overrun cleared by read", lsr0[1], 1'b0);
        for (int i = 0; i < 15; i++) pop1();
        #1;
        check("R8", "dropped byte not stored", rd0, 8'h4f);
        pop1(); #1;
        check("R2", "empty after drain", lsr0[0], 1'b0);

        modem_in = 4'b0100;
        tick(); tick(); #1;
        check("R9", "level after two flops", msr0, 8'h40);
        check("R9", "no delta yet", irqm0, 1'b0);
        tick(); #1;
        check("R9", "delta set", msr0, 8'h44);
        check("R9", "modem irq", irqm0, 1'b1);
        msr_rd = 1; tick(); #1;
        check("R9", "modem irq cleared by read", irqm0, 1'b0);

        for (int c = 0; c < 4000; c++) begin
            wr_en   = ($urandom_range(0, 99) < 45);
            wr_data = 8'($urandom);
            wr_fe   = ($urandom_range(0, 99) < 15);
            wr_brk  = ($urandom_range(0, 99) < 10);
            rd_en   = ($urandom_range(0, 99) < ((c / 500) % 2 == 0 ? 30 : 60));
            lsr_rd  = ($urandom_range(0, 99) < 10);
            msr_rd  = ($urandom_range(0, 99) < 10);
            if ($urandom_range(0, 99) < 5) modem_in = 4'($urandom);
            if ($urandom_range(0, 99) < 3) ie_line = ~ie_line;
            if ($urandom_range(0, 99) < 3) ie_modem = ~ie_modem;
            @(posedge clk); #1;
        end
        tick();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule